// File: doc/BRIEF.md
# Serial Driver Frame Loader and Strobe Sequencer

This block is the host-side controller for a chain of cascaded serial-input latched driver devices. A parallel frame word comes in on a valid/ready stream port. The block turns it into a sequence on four pins: one serial data line, one shift clock, one strobe and one blanking line. All four are timed from a fast system clock. After the strobe has moved the shifted bits into the drivers' latches, the block raises a single-cycle completion pulse and then accepts the next frame.

Every timing phase is a whole number of system-clock cycles, set by a parameter, with a minimum of one cycle. The phases are data setup before the shift clock rises, shift clock high time, data hold after the clock falls, the gap from the end of the last clock to the strobe, and the strobe width. The frame width is the channel count of one device times the number of devices in the chain.

A per-frame control pin, sampled when the frame is accepted, asks for a blanking window around the latch update. In that window the driver outputs stay off while the latches change.

The stream port follows these back-pressure rules:
- A frame is accepted on a clock edge where valid and ready are both high.
- Ready stays low from acceptance until the completion pulse, so the source must hold or re-present its word.
- Data or valid that changes while ready is low has no effect.

Top module: `drv_frame_loader`

## Requirements
- R1: Each frame produces exactly FRAME_W shift clock rising edges before its strobe. Bits go out most-significant first, so the k-th rising edge (k from 1) carries frame bit FRAME_W-k.
- R2: Serial data holds one value for at least SETUP_CYC system cycles before every shift clock rising edge.
- R3: Every shift clock high pulse lasts exactly CLKHI_CYC system cycles.
- R4: After a shift clock rising edge, serial data does not change for at least CLKHI_CYC+HOLD_CYC system cycles.
- R5: The strobe rises no earlier than CLKHI_CYC+HOLD_CYC+GAP_CYC system cycles after the last shift clock rising edge. The shift clock is low while the strobe is high.
- R6: Every strobe high pulse lasts exactly STROBE_CYC system cycles.
- R7: When the blank-around pin is 1 at acceptance, blanking is already high when the strobe rises. It falls exactly STROBE_CYC cycles after the strobe falls.
- R8: When the blank-around pin is 0 at acceptance, blanking stays low for the whole frame.
- R9: Ready is low from the cycle after acceptance until the completion pulse ends. The completion pulse lasts exactly one cycle, and ready is high again the next cycle. There is one pulse per accepted frame.
- R10: Frame data, valid and blank-around values presented while ready is low do not change the frame being sent.
- R11: After reset, ready is high and shift clock, strobe, blanking and completion are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_data | input | FRAME_W | Frame word, bit FRAME_W-1 shifted first |
| frame_valid | input | 1 | Frame word is offered |
| frame_ready | output | 1 | Loader can accept a frame |
| blank_around | input | 1 | Request blanking around this frame's latch update |
| ser_data | output | 1 | Serial data to the first device |
| ser_clk | output | 1 | Shift clock |
| latch_stb | output | 1 | Latch strobe |
| out_blank | output | 1 | Blanking, high turns driver outputs off |
| frame_done | output | 1 | One-cycle pulse after the latch update |

## Verification
A wrong bit counter or a slip in shift order shows up at the strobe edge that closes the frame. That frame's collected serial word then differs from the accepted one, or holds the wrong number of clocks. A phase timer loaded with the wrong count shows up within one bit period as a shift clock pulse or setup window of the wrong length. A sequencer state that skips or repeats a phase shows up at the latest at the strobe or blanking edges of that frame, as a wrong gap or width. A leak of the blank-around pin or of new data during busy time is caught at the strobe of the frame in flight, as a wrong blanking level or a wrong word.

// File: rtl/dfl_pkg.sv
package dfl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_HIGH   = 3'd2,
    ST_HOLD   = 3'd3,
    ST_GAP    = 3'd4,
    ST_STROBE = 3'd5,
    ST_POST   = 3'd6,
    ST_DONE   = 3'd7
  } dfl_state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dfl_phase_timer.sv
module dfl_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R3: a freshly loaded non-zero count must not report expiry next cycle
  a_r3_timer_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> !expired);
endmodule

// File: rtl/dfl_serializer.sv
module dfl_serializer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] word,
  input  logic         shift,
  output logic         msb,
  output logic         last
);
  localparam int BW = $clog2(W + 1);

  logic [W-1:0]  sh_q;
  logic [BW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load) begin
      sh_q   <= word;
      left_q <= BW'(W);
    end else if (shift) begin
      sh_q   <= {sh_q[W-2:0], 1'b0};
      left_q <= left_q - 1'b1;
    end
  end

  assign msb  = sh_q[W-1];
  assign last = (left_q == BW'(1));

  // R1: never shift past the end of a frame
  a_r1_no_overshift: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> (left_q > BW'(1)));
endmodule

// File: rtl/dfl_sequencer.sv
module dfl_sequencer
  import dfl_pkg::*;
#(
  parameter int CW         = 4,
  parameter int SETUP_CYC  = 2,
  parameter int CLKHI_CYC  = 3,
  parameter int HOLD_CYC   = 2,
  parameter int GAP_CYC    = 4,
  parameter int STROBE_CYC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          blank_req,
  input  logic          expired,
  input  logic          last_bit,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          ser_load,
  output logic          ser_shift,
  output logic          in_ready,
  output logic          sclk,
  output logic          stb,
  output logic          blank,
  output logic          done
);
  localparam logic [CW-1:0] L_SETUP  = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] L_CLKHI  = CW'(CLKHI_CYC - 1);
  localparam logic [CW-1:0] L_HOLD   = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] L_GAP    = CW'(GAP_CYC - 1);
  localparam logic [CW-1:0] L_STROBE = CW'(STROBE_CYC - 1);

  dfl_state_e st_q, st_d;
  logic       blank_lat_q;

  always_comb begin
    st_d      = st_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    ser_load  = 1'b0;
    ser_shift = 1'b0;
    unique case (st_q)
      ST_IDLE: if (in_valid) begin
        ser_load = 1'b1; tmr_load = 1'b1; tmr_val = L_SETUP; st_d = ST_SETUP;
      end
      ST_SETUP: if (expired) begin
        tmr_load = 1'b1; tmr_val = L_CLKHI; st_d = ST_HIGH;
      end
      ST_HIGH: if (expired) begin
        tmr_load = 1'b1; tmr_val = L_HOLD; st_d = ST_HOLD;
      end
      ST_HOLD: if (expired) begin
        tmr_load = 1'b1;
        if (last_bit) begin
          tmr_val = L_GAP; st_d = ST_GAP;
        end else begin
          ser_shift = 1'b1; tmr_val = L_SETUP; st_d = ST_SETUP;
        end
      end
      ST_GAP: if (expired) begin
        tmr_load = 1'b1; tmr_val = L_STROBE; st_d = ST_STROBE;
      end
      ST_STROBE: if (expired) begin
        if (blank_lat_q) begin
          tmr_load = 1'b1; tmr_val = L_STROBE; st_d = ST_POST;
        end else begin
          st_d = ST_DONE;
        end
      end
      ST_POST: if (expired) st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      blank_lat_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && in_valid) blank_lat_q <= blank_req;
    end
  end

  assign in_ready = (st_q == ST_IDLE);
  assign sclk     = (st_q == ST_HIGH);
  assign stb      = (st_q == ST_STROBE);
  assign done     = (st_q == ST_DONE);
  assign blank    = blank_lat_q &&
                    (st_q == ST_GAP || st_q == ST_STROBE || st_q == ST_POST);

  // R9: ready drops after acceptance
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid) |=> !in_ready);
  // R9: completion is a single cycle and ready returns right after
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && in_ready));
  // R5: shift clock never overlaps strobe
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> !sclk);
  // R7: strobe rises inside an open blanking window when requested
  a_r7_blank_covers: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stb) && blank_lat_q) |-> blank);
  // R8: no blanking without a request
  a_r8_no_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_lat_q |-> !blank);
endmodule

// File: rtl/drv_frame_loader.sv
module drv_frame_loader
  import dfl_pkg::*;
#(
  parameter int CHANNELS   = 8,
  parameter int DEVICES    = 2,
  parameter int SETUP_CYC  = 2,
  parameter int CLKHI_CYC  = 3,
  parameter int HOLD_CYC   = 2,
  parameter int GAP_CYC    = 4,
  parameter int STROBE_CYC = 3,
  localparam int FRAME_W   = CHANNELS * DEVICES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FRAME_W-1:0] frame_data,
  input  logic               frame_valid,
  output logic               frame_ready,
  input  logic               blank_around,
  output logic               ser_data,
  output logic               ser_clk,
  output logic               latch_stb,
  output logic               out_blank,
  output logic               frame_done
);
  localparam int MAX_PH = max_of(max_of(max_of(SETUP_CYC, CLKHI_CYC),
                                        max_of(HOLD_CYC, GAP_CYC)), STROBE_CYC);
  localparam int CW     = $clog2(MAX_PH + 1);

  logic          tmr_load, tmr_exp, ser_load, ser_shift, last_bit;
  logic [CW-1:0] tmr_val;

  dfl_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  dfl_serializer #(.W(FRAME_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .load(ser_load), .word(frame_data),
    .shift(ser_shift), .msb(ser_data), .last(last_bit)
  );

  dfl_sequencer #(
    .CW(CW), .SETUP_CYC(SETUP_CYC), .CLKHI_CYC(CLKHI_CYC), .HOLD_CYC(HOLD_CYC),
    .GAP_CYC(GAP_CYC), .STROBE_CYC(STROBE_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(frame_valid), .blank_req(blank_around),
    .expired(tmr_exp), .last_bit(last_bit), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .ser_load(ser_load), .ser_shift(ser_shift), .in_ready(frame_ready),
    .sclk(ser_clk), .stb(latch_stb), .blank(out_blank), .done(frame_done)
  );

  // R2: serial data is steady in the cycle before a shift clock rise
  a_r2_setup_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk) |-> $stable(ser_data));
  // R4: serial data does not move while the shift clock is high
  a_r4_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));
endmodule

// File: tb/drv_frame_loader_tb.sv
module drv_frame_loader_tb;
  localparam int CH = 8, DEV = 2, W = CH * DEV;
  localparam int SU = 2, HI = 3, HO = 2, GP = 4, SB = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] frame_data = '0;
  logic frame_valid = 1'b0, blank_around = 1'b0;
  logic frame_ready, ser_data, ser_clk, latch_stb, out_blank, frame_done;

  always #2.5 clk = ~clk;

  drv_frame_loader #(.CHANNELS(CH), .DEVICES(DEV), .SETUP_CYC(SU), .CLKHI_CYC(HI),
    .HOLD_CYC(HO), .GAP_CYC(GP), .STROBE_CYC(SB)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_data(frame_data), .frame_valid(frame_valid),
    .frame_ready(frame_ready), .blank_around(blank_around), .ser_data(ser_data),
    .ser_clk(ser_clk), .latch_stb(latch_stb), .out_blank(out_blank),
    .frame_done(frame_done)
  );

  int checks = 0, fails = 0, sent = 0, dones = 0, cyc = 0;
  logic [W-1:0] exp_q[$];
  logic         expb_q[$];
  logic         cur_blank = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // driver: offers a frame, pushes expectation on acceptance, optional junk while busy
  task automatic send(input logic [W-1:0] d, input logic b, input int junk);
    @(negedge clk);
    frame_valid = 1'b1; frame_data = d; blank_around = b;
    while (!frame_ready) @(negedge clk);
    exp_q.push_back(d); expb_q.push_back(b); sent++;
    @(negedge clk);
    // R10: junk offered while ready is low must be ignored
    for (int i = 0; i < junk; i++) begin
      frame_valid = 1'b1; frame_data = ~d; blank_around = ~b;
      chk(frame_ready == 1'b0, "R9 ready low while busy", frame_ready, 0);
      @(negedge clk);
    end
    frame_valid = 1'b0; frame_data = '0; blank_around = 1'b0;
  endtask

  // monitor
  logic p_sclk = 0, p_stb = 0, p_blank = 0, p_sdata = 0, p_done = 0;
  int hi_run = 0, stab = 0, since_rise = 1000, stb_run = 0, since_fall = -1, nbits = 0;
  logic [W-1:0] acc = '0;
  logic frame_blanked = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      since_rise++;
      if (ser_data != p_sdata) begin
        stab = 1;
        chk(since_rise >= HI + HO, "R4 hold after clock rise", since_rise, HI + HO);
      end else stab++;
      if (ser_clk && !p_sclk) begin
        chk(stab - 1 >= SU, "R2 setup before clock rise", stab - 1, SU);
        acc = {acc[W-2:0], ser_data};
        nbits++;
        since_rise = 0;
      end
      if (ser_clk) hi_run++;
      if (!ser_clk && p_sclk) begin
        chk(hi_run == HI, "R3 clock high width", hi_run, HI);
        hi_run = 0;
      end
      if (out_blank) frame_blanked = 1;
      if (latch_stb && !p_stb) begin
        chk(since_rise >= HI + HO + GP, "R5 clock-to-strobe gap", since_rise, HI + HO + GP);
        chk(!ser_clk, "R5 clock low during strobe", ser_clk, 0);
        chk(frame_ready == 1'b0, "R9 ready low before strobe", frame_ready, 0);
        if (exp_q.size() == 0) chk(0, "R1 unexpected frame", acc, 0);
        else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          cur_blank = expb_q.pop_front();
          chk(nbits == W, "R1 clock count", nbits, W);
          chk(acc == e, "R1/R10 shifted word", acc, e);
          if (cur_blank) chk(out_blank == 1'b1, "R7 blank before strobe", out_blank, 1);
        end
        nbits = 0;
      end
      if (latch_stb) stb_run++;
      if (!latch_stb && p_stb) begin
        chk(stb_run == SB, "R6 strobe width", stb_run, SB);
        stb_run = 0;
        since_fall = 0;
      end else if (since_fall >= 0) since_fall++;
      if (!out_blank && p_blank)
        chk(since_fall == SB, "R7 blank falls after strobe", since_fall, SB);
      if (p_done) begin
        chk(!frame_done, "R9 done one cycle", frame_done, 0);
        chk(frame_ready, "R9 ready after done", frame_ready, 1);
      end
      if (frame_done) begin
        dones++;
        chk(!frame_ready, "R9 ready low at done", frame_ready, 0);
        if (!cur_blank) chk(!frame_blanked, "R8 no blanking", frame_blanked, 0);
        frame_blanked = 0;
        since_fall = -1;
      end
      p_sclk = ser_clk; p_stb = latch_stb; p_blank = out_blank;
      p_sdata = ser_data; p_done = frame_done;
      if (cyc > 100000) begin
        chk(0, "watchdog expired", cyc, 100000);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(frame_ready == 1'b1, "R11 ready after reset", frame_ready, 1);
    chk({ser_clk, latch_stb, out_blank, frame_done} == 4'b0, "R11 outputs low",
        {ser_clk, latch_stb, out_blank, frame_done}, 0);
    rst_n = 1'b1;
    send(16'hA5C3, 1'b0, 0);
    send(16'h8001, 1'b1, 0);
    send(16'hFFFF, 1'b0, 20);
    send(16'h0000, 1'b1, 30);
    send(16'h1234, 1'b0, 5);
    send(16'h7FFE, 1'b1, 0);
    for (int k = 0; k < 4; k++) send(16'h3C5A ^ (16'h1111 * k), k[0], 3);
    while (dones < sent) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(dones == sent, "R9 one done per frame", dones, sent);
    chk(exp_q.size() == 0, "R1 all frames latched", exp_q.size(), 0);
    finish_run();
  end
endmodule